// File: doc/BRIEF.md
# Two-Level Interrupt Arbiter with Vectoring

This block sits beside an 8-bit controller core. It gathers eight interrupt requests, masks them, ranks them and hands the core one vector address at a time. The eight requests are three external pins, three timer overflows, one serial-port request and one request from an HDLC framing engine. Software loads four small configuration registers through a write port: the enable mask, the level map, the pin polarity and the trigger mode. The HDLC request has no bit in the enable mask. It is gated by a separate enable input that comes from that engine's own control register.

Each request is placed in a high or a low level. A high request beats any low one. Inside one level the lowest source number wins. The core takes a vector by pulsing `irq_ack` while `irq_req` is high. The block then marks that level as in service and pulses a one-hot `src_ack` back to the winning source. A return pulse closes the innermost open level. Because of this, a low handler can be pre-empted only by a high request, and a high handler cannot be pre-empted at all.

External pins pass through a synchronizer. Each pin is seen through its polarity bit. The first two pins can be set to edge or level sensing. The third pin is always edge-sensed, with a latched pending flag that is cleared when its vector is taken.

Top module: `irq_arbiter`

## Requirements
- R1: After reset the enable, level, polarity and mode registers are zero, so `irq_req`, `src_ack` and `ext_pend` are all low.
- R2: Source n (0 INT0 pin, 1 timer 0, 2 INT1 pin, 3 timer 1, 4 serial, 5 timer 2, 6 INT2 pin, 7 HDLC) is presented as vector 8·n+3, giving 0x03, 0x0B, 0x13, 0x1B, 0x23, 0x2B, 0x33 and 0x3B.
- R3: Enable register (config address 0) bit 7 is a global gate. While it is 0 no request is raised, whatever the other bits hold.
- R4: Enable bits 0..6 each mask source 0..6 (bit 6 masks INT2). Source 7 (HDLC) is masked only by the `hdlc_irq_en` input. A masked INT2 edge still sets `ext_pend[2]` and is raised once its mask bit is set.
- R5: Level register (config address 1) bit n = 1 puts source n in the high level. An enabled high request always wins over low ones. Within one level the lowest source number wins.
- R6: INT2 is edge-only. Polarity register (config address 2) bit 2 = 0 selects falling edges and bit 2 = 1 selects rising edges. Each qualifying edge sets `ext_pend[2]` once. Taking vector 0x33 clears it. A change of polarity alone sets nothing.
- R7: Mode register (config address 3) bit 0 / bit 1 = 1 makes INT0 / INT1 edge-sensed, using a pending flag (`ext_pend[0]`/`ext_pend[1]`) that holds after the pin returns and is cleared when its vector is taken. A mode bit of 0 makes the request follow the pin level with no latching.
- R8: Polarity bits 0 and 1 invert INT0 and INT1. With a bit of 0 the pin is active low; with a bit of 1 it is active high.
- R9: A taken vector opens its level. While the high level is open nothing is raised. While only the low level is open only high requests are raised. Each `irq_ret` pulse closes the high level if it is open, and otherwise the low level.
- R10: `src_ack` is one-hot on the winning source in the cycle where `irq_ack` and `irq_req` are both high, and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 enable, 1 level, 2 polarity, 3 mode |
| cfg_wdata | input | 8 | Configuration write data |
| ext_pin | input | 3 | External interrupt pins INT0..INT2 (asynchronous) |
| tmr0_req | input | 1 | Timer 0 overflow request |
| tmr1_req | input | 1 | Timer 1 overflow request |
| tmr2_req | input | 1 | Timer 2 request |
| ser_req | input | 1 | Serial receive/transmit request |
| hdlc_req | input | 1 | HDLC engine request |
| hdlc_irq_en | input | 1 | HDLC request mask, from that engine's control register |
| irq_ack | input | 1 | Core takes the presented vector |
| irq_ret | input | 1 | Core returns from a handler |
| irq_req | output | 1 | A vector is presented |
| irq_vector | output | 8 | Vector address of the winning source |
| src_ack | output | 8 | One-hot acknowledge to the winning source |
| ext_pend | output | 3 | Edge pending flags of INT0..INT2 |

## Verification
Every source is first raised alone, so that a wrong vector stride or a swapped source slot shows up directly. Pairs and triples of timer, serial and HDLC requests are then raised under several level maps. This separates the level comparison from the fixed in-level order. Pin waveforms (falls, rises, held levels and returns) are driven under each polarity and mode, to tell edge latching from level following and a true edge from a polarity change. Nested take/return sequences show whether same-level blocking and the innermost-first release on return are kept correctly.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int NUM_SRC  = 8;
  localparam int NUM_MODE = 2;

  typedef enum logic [1:0] {
    CFG_ENA  = 2'd0,
    CFG_PRI  = 2'd1,
    CFG_POL  = 2'd2,
    CFG_MODE = 2'd3
  } cfg_addr_e;

  // Source slot of each external pin in the fixed arbitration order.
  function automatic int ext_src_idx(int g);
    case (g)
      0:       return 0;
      1:       return 2;
      default: return 6;
    endcase
  endfunction

endpackage

// File: rtl/irq_pin_cond.sv
module irq_pin_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol,
  output logic act,
  output logic edge_hit
);

  logic [SYNC_STAGES-1:0] sync_q, sync_nxt;
  logic                   prev_q;
  logic                   raw;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb sync_nxt = pin;
    end else begin : g_many
      always_comb sync_nxt = {sync_q[SYNC_STAGES-2:0], pin};
    end
  endgenerate

  assign raw = sync_q[SYNC_STAGES-1];

  // The previous raw sample is judged under the current polarity, so a
  // polarity write alone never looks like an edge.
  assign act      = pol ? raw : ~raw;
  assign edge_hit = act & ~(pol ? prev_q : ~prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_nxt;
      prev_q <= raw;
    end
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NUM_EXT     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STRIDE  = 8,
  parameter int VEC_W       = 8,
  parameter int CFG_W       = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_addr,
  input  logic [CFG_W-1:0]    cfg_wdata,
  input  logic [NUM_EXT-1:0]  ext_pin,
  input  logic                tmr0_req,
  input  logic                tmr1_req,
  input  logic                tmr2_req,
  input  logic                ser_req,
  input  logic                hdlc_req,
  input  logic                hdlc_irq_en,
  input  logic                irq_ack,
  input  logic                irq_ret,
  output logic                irq_req,
  output logic [VEC_W-1:0]    irq_vector,
  output logic [NUM_SRC-1:0]  src_ack,
  output logic [NUM_EXT-1:0]  ext_pend
);

  localparam int IDX_W = $clog2(NUM_SRC);

  logic [CFG_W-1:0]    ena_q, ena_nxt, pri_q, pri_nxt;
  logic [NUM_EXT-1:0]  pol_q, pol_nxt;
  logic [NUM_MODE-1:0] mode_q, mode_nxt;
  logic [NUM_EXT-1:0]  pend_q, pend_nxt;
  logic                ins_hi_q, ins_hi_nxt, ins_lo_q, ins_lo_nxt;

  logic [NUM_EXT-1:0]  act, edge_hit, edge_mode, ext_req;
  logic [NUM_SRC-1:0]  req_raw, mask, elig;
  logic                hi_found, lo_found, win_hi, take;
  logic [IDX_W-1:0]    hi_idx, lo_idx, win_idx;

  // Pin conditioning, one instance per external pin.
  genvar g;
  generate
    for (g = 0; g < NUM_EXT; g++) begin : g_pin
      irq_pin_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_pin[g]),
        .pol      (pol_q[g]),
        .act      (act[g]),
        .edge_hit (edge_hit[g])
      );
    end
  endgenerate

  // Pins without a mode bit are always edge-sensed.
  assign edge_mode = {{(NUM_EXT-NUM_MODE){1'b1}}, mode_q};
  assign ext_req   = (edge_mode & pend_q) | (~edge_mode & act);

  assign req_raw = {hdlc_req, ext_req[2], tmr2_req, ser_req,
                    tmr1_req, ext_req[1], tmr0_req, ext_req[0]};
  assign mask    = {hdlc_irq_en, ena_q[NUM_SRC-2:0]} & {NUM_SRC{ena_q[CFG_W-1]}};
  assign elig    = req_raw & mask;

  irq_pick #(.N(NUM_SRC)) u_pick_hi (
    .req   (elig & pri_q[NUM_SRC-1:0]),
    .found (hi_found),
    .idx   (hi_idx)
  );

  irq_pick #(.N(NUM_SRC)) u_pick_lo (
    .req   (elig & ~pri_q[NUM_SRC-1:0]),
    .found (lo_found),
    .idx   (lo_idx)
  );

  // Winner selection against the open service levels.
  always_comb begin
    irq_req = 1'b0;
    win_hi  = 1'b0;
    win_idx = lo_idx;
    if (!ins_hi_q) begin
      if (hi_found) begin
        irq_req = 1'b1;
        win_hi  = 1'b1;
        win_idx = hi_idx;
      end else if (lo_found && !ins_lo_q) begin
        irq_req = 1'b1;
      end
    end
  end

  assign irq_vector = VEC_W'(VEC_BASE + VEC_STRIDE * int'(win_idx));
  assign take       = irq_req & irq_ack;
  assign src_ack    = take ? (NUM_SRC'(1) << win_idx) : '0;
  assign ext_pend   = pend_q;

  // Next state: configuration, pending flags, service levels.
  always_comb begin
    ena_nxt  = ena_q;
    pri_nxt  = pri_q;
    pol_nxt  = pol_q;
    mode_nxt = mode_q;
    if (cfg_we) begin
      case (cfg_addr_e'(cfg_addr))
        CFG_ENA:  ena_nxt  = cfg_wdata;
        CFG_PRI:  pri_nxt  = cfg_wdata;
        CFG_POL:  pol_nxt  = cfg_wdata[NUM_EXT-1:0];
        default:  mode_nxt = cfg_wdata[NUM_MODE-1:0];
      endcase
    end

    pend_nxt = pend_q;
    for (int i = 0; i < NUM_EXT; i++) begin
      if (take && (win_idx == IDX_W'(ext_src_idx(i)))) pend_nxt[i] = 1'b0;
      if (edge_hit[i])                                 pend_nxt[i] = 1'b1;
      if (!edge_mode[i])                               pend_nxt[i] = 1'b0;
    end

    ins_hi_nxt = ins_hi_q;
    ins_lo_nxt = ins_lo_q;
    if (take) begin
      if (win_hi) ins_hi_nxt = 1'b1;
      else        ins_lo_nxt = 1'b1;
    end else if (irq_ret) begin
      if (ins_hi_q) ins_hi_nxt = 1'b0;
      else          ins_lo_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q    <= '0;
      pri_q    <= '0;
      pol_q    <= '0;
      mode_q   <= '0;
      pend_q   <= '0;
      ins_hi_q <= 1'b0;
      ins_lo_q <= 1'b0;
    end else begin
      ena_q    <= ena_nxt;
      pri_q    <= pri_nxt;
      pol_q    <= pol_nxt;
      mode_q   <= mode_nxt;
      pend_q   <= pend_nxt;
      ins_hi_q <= ins_hi_nxt;
      ins_lo_q <= ins_lo_nxt;
    end
  end

endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_req,
  input logic       irq_ack,
  input logic [7:0] irq_vector,
  input logic [7:0] src_ack,
  input logic [7:0] ena_q,
  input logic       ins_hi_q
);

  assert_ack_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_ack));

  assert_ack_qualified_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_ack) |-> (irq_ack && irq_req));

  assert_vec_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vector[2:0] == 3'd3));

  assert_global_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ena_q[7] |-> !irq_req);

  assert_high_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ins_hi_q |-> !irq_req);

  assert_ack_opens_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> !$past(ins_hi_q) || !irq_req);

endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_req    (irq_req),
  .irq_ack    (irq_ack),
  .irq_vector (irq_vector),
  .src_ack    (src_ack),
  .ena_q      (ena_q),
  .ins_hi_q   (ins_hi_q)
);

// File: tb/irq_arbiter_tb_top.sv
module irq_arbiter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [1:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic [2:0] ext_pin;
  logic       tmr0_req, tmr1_req, tmr2_req, ser_req, hdlc_req, hdlc_irq_en;
  logic       irq_ack, irq_ret;
  logic       irq_req;
  logic [7:0] irq_vector;
  logic [7:0] src_ack;
  logic [2:0] ext_pend;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  irq_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ext_pin(ext_pin), .tmr0_req(tmr0_req),
    .tmr1_req(tmr1_req), .tmr2_req(tmr2_req), .ser_req(ser_req),
    .hdlc_req(hdlc_req), .hdlc_irq_en(hdlc_irq_en), .irq_ack(irq_ack),
    .irq_ret(irq_ret), .irq_req(irq_req), .irq_vector(irq_vector),
    .src_ack(src_ack), .ext_pend(ext_pend)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Presented request as one value: 0 when idle, else the vector.
  function automatic logic [31:0] pres();
    return irq_req ? 32'(irq_vector) : 32'h0;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; ext_pin = 3'b111;
    tmr0_req = 0; tmr1_req = 0; tmr2_req = 0; ser_req = 0; hdlc_req = 0;
    hdlc_irq_en = 0; irq_ack = 0; irq_ret = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    cyc(1);
    cfg_we = 0;
  endtask

  task automatic take(output logic [7:0] vec, output logic [7:0] ack);
    irq_ack = 1;
    #2;
    vec = irq_vector;
    ack = src_ack;
    cyc(1);
    irq_ack = 0;
  endtask

  task automatic ret();
    irq_ret = 1;
    cyc(1);
    irq_ret = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 irq_req after reset", irq_req, 0);
    chk("R1 src_ack after reset", src_ack, 0);
    chk("R1 ext_pend after reset", ext_pend, 0);
    tmr0_req = 1; ser_req = 1; cyc(1);
    chk("R1 zero enables block", irq_req, 0);
    tmr0_req = 0; ser_req = 0;
  endtask

  task automatic t_vectors();
    logic [7:0] v, a;
    do_reset();
    wr(0, 8'hFF); hdlc_irq_en = 1;
    tmr0_req = 1; cyc(1); chk("R2 timer0 vector", pres(), 32'h0B); tmr0_req = 0;
    tmr1_req = 1; cyc(1); chk("R2 timer1 vector", pres(), 32'h1B); tmr1_req = 0;
    ser_req  = 1; cyc(1); chk("R2 serial vector", pres(), 32'h23); ser_req  = 0;
    tmr2_req = 1; cyc(1); chk("R2 timer2 vector", pres(), 32'h2B); tmr2_req = 0;
    hdlc_req = 1; cyc(1); chk("R2 hdlc vector",   pres(), 32'h3B); hdlc_req = 0;
    ext_pin[0] = 0; cyc(3); chk("R2 int0 vector", pres(), 32'h03);
    ext_pin[0] = 1; cyc(3);
    ext_pin[1] = 0; cyc(3); chk("R2 int1 vector", pres(), 32'h13);
    ext_pin[1] = 1; cyc(3);
    ext_pin[2] = 0; cyc(4); chk("R2 int2 vector", pres(), 32'h33);
    take(v, a); chk("R10 int2 ack onehot", a, 8'h40);
    ret(); ext_pin[2] = 1; cyc(3);
    chk("R2 idle after sweep", irq_req, 0);
  endtask

  task automatic t_gate();
    logic [7:0] v, a;
    do_reset();
    tmr0_req = 1;
    wr(0, 8'h02); chk("R3 global gate off", irq_req, 0);
    wr(0, 8'h80); chk("R4 timer0 masked", irq_req, 0);
    wr(0, 8'h82); chk("R4 timer0 enabled", pres(), 32'h0B);
    tmr0_req = 0;
    wr(0, 8'h80);
    ext_pin[2] = 0; cyc(4);
    chk("R4 masked int2 still pending", ext_pend[2], 1);
    chk("R4 int2 masked by bit6", irq_req, 0);
    wr(0, 8'hC0); chk("R4 int2 unmasked", pres(), 32'h33);
    take(v, a); ret(); ext_pin[2] = 1; cyc(3);
    wr(0, 8'h80); hdlc_req = 1; cyc(1);
    chk("R4 hdlc masked by input", irq_req, 0);
    hdlc_irq_en = 1; cyc(1);
    chk("R4 hdlc enabled by input", pres(), 32'h3B);
    hdlc_req = 0;
  endtask

  task automatic t_priority();
    do_reset();
    wr(0, 8'h9A); tmr0_req = 1; ser_req = 1;
    wr(1, 8'h00); chk("R5 same level lowest wins", pres(), 32'h0B);
    wr(1, 8'h10); chk("R5 high serial beats timer0", pres(), 32'h23);
    tmr1_req = 1; cyc(1);
    chk("R5 high serial beats low timer1", pres(), 32'h23);
    wr(1, 8'h18); chk("R5 lowest within high level", pres(), 32'h1B);
    hdlc_irq_en = 1; hdlc_req = 1;
    wr(1, 8'h80); chk("R5 high hdlc beats low timers", pres(), 32'h3B);
    tmr0_req = 0; tmr1_req = 0; ser_req = 0; hdlc_req = 0;
  endtask

  task automatic t_int2_edge();
    logic [7:0] v, a;
    do_reset();
    wr(0, 8'hC0);
    ext_pin[2] = 0; cyc(4);
    chk("R6 falling edge pending", ext_pend[2], 1);
    take(v, a); chk("R6 int2 taken", v, 8'h33);
    chk("R6 flag cleared by take", ext_pend[2], 0);
    cyc(4); chk("R6 held low sets once", ext_pend[2], 0);
    ret();
    ext_pin[2] = 1; cyc(4);
    chk("R6 rising ignored when falling selected", ext_pend[2], 0);
    wr(2, 8'h04); cyc(3);
    chk("R6 polarity write alone no edge", ext_pend[2], 0);
    ext_pin[2] = 0; cyc(4);
    chk("R6 falling ignored when rising selected", ext_pend[2], 0);
    ext_pin[2] = 1; cyc(4);
    chk("R6 rising edge pending", ext_pend[2], 1);
    chk("R6 rising edge raised", pres(), 32'h33);
  endtask

  task automatic t_mode();
    logic [7:0] v, a;
    do_reset();
    wr(0, 8'h85); wr(3, 8'h01);
    ext_pin[0] = 0; cyc(4);
    chk("R7 int0 edge pending", ext_pend[0], 1);
    ext_pin[0] = 1; cyc(4);
    chk("R7 int0 edge latched", pres(), 32'h03);
    take(v, a);
    chk("R10 int0 ack onehot", a, 8'h01);
    chk("R7 int0 flag cleared", ext_pend[0], 0);
    chk("R10 ack pulse ends", src_ack, 0);
    ret(); cyc(1);
    chk("R7 int0 not raised again", irq_req, 0);
    ext_pin[1] = 0; cyc(3);
    chk("R7 int1 level raised", pres(), 32'h13);
    chk("R7 int1 level no flag", ext_pend[1], 0);
    ext_pin[1] = 1; cyc(3);
    chk("R7 int1 level follows pin", irq_req, 0);
    wr(2, 8'h02); cyc(1);
    chk("R8 int1 active high", pres(), 32'h13);
    ext_pin[1] = 0; cyc(3);
    chk("R8 int1 low inactive", irq_req, 0);
    ext_pin[1] = 1; cyc(3);
  endtask

  task automatic t_nest();
    logic [7:0] v, a;
    do_reset();
    wr(0, 8'hBA); wr(1, 8'h28);
    tmr0_req = 1; ser_req = 1; cyc(1);
    take(v, a); chk("R9 low take", v, 8'h0B);
    chk("R10 timer0 ack", a, 8'h02);
    tmr0_req = 0; cyc(1);
    chk("R9 low blocked by open low", irq_req, 0);
    tmr1_req = 1; cyc(1);
    chk("R9 high preempts low", pres(), 32'h1B);
    take(v, a); tmr1_req = 0;
    tmr2_req = 1; cyc(1);
    chk("R9 high blocked by open high", irq_req, 0);
    ret();
    chk("R9 return closes high first", pres(), 32'h2B);
    take(v, a); tmr2_req = 0; ret();
    chk("R9 low still open", irq_req, 0);
    ret();
    chk("R9 second return closes low", pres(), 32'h23);
    take(v, a); ser_req = 0; ret();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_vectors();
    t_gate();
    t_priority();
    t_int2_edge();
    t_mode();
    t_nest();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule